// File: doc/BRIEF.md
# Cascade acknowledge steering for a priority interrupt controller

This block lets several priority interrupt controllers share one processor interrupt line. One device runs as master and the rest as slaves. Each slave's request output feeds one master input. A configuration word tells a master which of its inputs lead to a slave. The same word gives a slave its own 3-bit identifier, which is the number of the master input it drives. The block contains a fixed-priority resolver, with input 0 highest. The resolver only grants a request that is unmasked and that outranks every input already in service. Its result raises the request output.

The processor answers a request with two acknowledge pulses. When the first pulse arrives, the block captures the current winner and the current mode.

- **Master with a cascaded winner:** the master places the winner's input number on the 3-bit cascade bus. It holds it there for the rest of the acknowledge cycle and leaves the data bus to the slave.
- **Master with a direct winner:** the master keeps the cascade bus at zero and drives its own vector during the second pulse.
- **Slave:** a slave does nothing on the first pulse. During the second pulse it drives its vector only when the cascade bus carries its identifier.

A vector is the 5-bit type base followed by the 3-bit winning input number.

Top module: `casc_ack_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, int_req, cas_out, data_oe and data_out are all zero.
- R2: One clock after the inputs settle, int_req is 1 exactly when some input n meets all of the following: its irq_lines bit is 1, its irq_mask bit is 0, and every in_service bit at index n or below is 0. Index 0 has the highest priority.
- R3: The winner, its slave-attached status and the master/slave mode are captured at the clock edge that first samples ack high. Later changes to the requests, the mask or cfg_word do not alter that acknowledge cycle.
- R4: In master mode with a winner n whose cfg_word bit n is 1, cas_out equals n. It holds that value from the edge that samples the first pulse high until the edge that samples the second pulse low.
- R5: In master mode with a winner whose cfg_word bit is 0, cas_out stays 0. data_out equals {vec_base, n} while data_oe is high.
- R6: cas_out is 0 outside acknowledge cycles and always 0 in slave mode (is_master = 0).
- R7: A slave never asserts data_oe during the first pulse or the gap between pulses. During the second pulse it asserts data_oe only if cas_in equals cfg_word[2:0]. The upper cfg_word bits are ignored in slave mode.
- R8: data_oe is high only from the edge that samples the second pulse high until the edge that samples it low. data_out is 0 whenever data_oe is low.
- R9: If there is no winner when the first pulse is sampled, nothing is driven for that acknowledge cycle.
- R10: A master whose winner is cascaded never asserts data_oe, including when the winner is input 0 and cas_out therefore reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_word | input | 8 | Master: slave-attached bitmap; slave: identifier in bits 2:0 |
| vec_base | input | 5 | Upper five vector bits |
| irq_lines | input | 8 | Request inputs |
| irq_mask | input | 8 | 1 masks the matching input |
| in_service | input | 8 | Inputs currently being serviced |
| ack | input | 1 | Acknowledge strobe, high during each pulse |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| int_req | output | 1 | Registered request toward processor or master |
| cas_out | output | 3 | Cascade bus driven by a master |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Data bus output enable |

## Verification
int_req trails its inputs by one register, so the bench checks it one clock after applying a pattern. The acknowledge phase is registered once. As a result, cas_out and data_oe respond on the edge that samples each change of ack, and the bench checks them at the falling clock edge that follows each ack transition. Each acknowledge step is checked in order: first pulse, gap, second pulse, then idle. This places the check for every drive window in the cycle in which that window must be open or shut.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_GAP    = 2'd2,
    PH_SECOND = 2'd3
  } ack_phase_t;
endpackage

// File: rtl/casc_prio.sv
module casc_prio #(
  parameter int N_IN  = 8,
  parameter int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  req,
  input  logic [N_IN-1:0]  mask,
  input  logic [N_IN-1:0]  insrv,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx
);
  // inputs strictly above the highest-priority in-service bit
  function automatic logic [N_IN-1:0] above_service(input logic [N_IN-1:0] s);
    logic [N_IN-1:0] a;
    logic hit;
    a   = '0;
    hit = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (s[i]) hit = 1'b1;
      a[i] = !hit;
    end
    return a;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_IN-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_IN - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [N_IN-1:0] cand;

  always_comb begin
    cand      = req & ~mask & above_service(insrv);
    win_valid = |cand;
    win_idx   = lowest_set(cand);
  end
endmodule

// File: rtl/casc_seq.sv
module casc_seq
  import casc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  output ack_phase_t phase,
  output logic       take
);
  ack_phase_t phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:   if (ack)  phase_nx = PH_FIRST;
      PH_FIRST:  if (!ack) phase_nx = PH_GAP;
      PH_GAP:    if (ack)  phase_nx = PH_SECOND;
      PH_SECOND: if (!ack) phase_nx = PH_IDLE;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  assign take = (phase == PH_IDLE) && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/casc_drive.sv
module casc_drive
  import casc_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int IDX_W  = $clog2(N_IN),
  parameter int VEC_W  = 8,
  parameter int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ack_phase_t        phase,
  input  logic              take,
  input  logic              win_valid,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              is_master,
  input  logic [N_IN-1:0]   cfg_word,
  input  logic [BASE_W-1:0] vec_base,
  input  logic [IDX_W-1:0]  cas_in,
  output logic [IDX_W-1:0]  cas_out,
  output logic [VEC_W-1:0]  data_out,
  output logic              data_oe,
  output logic              id_hit
);
  function automatic logic [VEC_W-1:0] build_vector(input logic [BASE_W-1:0] b,
                                                    input logic [IDX_W-1:0] n);
    return {b, n};
  endfunction

  logic             lat_valid;
  logic             lat_master;
  logic             lat_casc;
  logic [IDX_W-1:0] lat_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_valid  <= 1'b0;
      lat_master <= 1'b0;
      lat_casc   <= 1'b0;
      lat_idx    <= '0;
    end else if (take) begin
      lat_valid  <= win_valid;
      lat_master <= is_master;
      lat_casc   <= is_master && win_valid && cfg_word[win_idx];
      lat_idx    <= win_idx;
    end
  end

  assign id_hit = (cas_in == cfg_word[IDX_W-1:0]);

  always_comb begin
    cas_out  = (phase != PH_IDLE && lat_casc) ? lat_idx : '0;
    data_oe  = (phase == PH_SECOND) && lat_valid &&
               (lat_master ? !lat_casc : id_hit);
    data_out = data_oe ? build_vector(vec_base, lat_idx) : '0;
  end
endmodule

// File: rtl/casc_ack_unit.sv
module casc_ack_unit
  import casc_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int IDX_W  = $clog2(N_IN),
  parameter int VEC_W  = 8,
  parameter int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic [N_IN-1:0]   cfg_word,
  input  logic [BASE_W-1:0] vec_base,
  input  logic [N_IN-1:0]   irq_lines,
  input  logic [N_IN-1:0]   irq_mask,
  input  logic [N_IN-1:0]   in_service,
  input  logic              ack,
  input  logic [IDX_W-1:0]  cas_in,
  output logic              int_req,
  output logic [IDX_W-1:0]  cas_out,
  output logic [VEC_W-1:0]  data_out,
  output logic              data_oe
);
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  ack_phase_t       phase;
  logic             take;
  logic             id_hit;

  casc_prio #(.N_IN(N_IN), .IDX_W(IDX_W)) u_prio (
    .req(irq_lines), .mask(irq_mask), .insrv(in_service),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  casc_seq u_seq (.clk(clk), .rst_n(rst_n), .ack(ack), .phase(phase), .take(take));

  casc_drive #(.N_IN(N_IN), .IDX_W(IDX_W), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .phase(phase), .take(take),
    .win_valid(win_valid), .win_idx(win_idx), .is_master(is_master),
    .cfg_word(cfg_word), .vec_base(vec_base), .cas_in(cas_in),
    .cas_out(cas_out), .data_out(data_out), .data_oe(data_oe), .id_hit(id_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) int_req <= 1'b0;
    else        int_req <= win_valid;
  end
endmodule

// File: rtl/casc_ack_chk.sv
module casc_ack_chk
  import casc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input ack_phase_t       phase,
  input logic             win_valid,
  input logic             int_req,
  input logic [IDX_W-1:0] cas_out,
  input logic [VEC_W-1:0] data_out,
  input logic             data_oe
);
  a_r2_req_follows_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> $past(win_valid));

  a_r6_cas_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (cas_out == '0));

  a_r4_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(cas_out));

  a_r7_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST || phase == PH_GAP) |-> !data_oe);

  a_r8_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (phase == PH_SECOND));

  a_r8_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  a_r10_cas_excludes_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_out != '0) |-> !data_oe);
endmodule

bind casc_ack_unit casc_ack_chk #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .win_valid(win_valid),
  .int_req(int_req), .cas_out(cas_out), .data_out(data_out), .data_oe(data_oe)
);

// File: tb/casc_ack_unit_bench.sv
`timescale 1ns/1ps
module casc_ack_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       is_master;
  logic [7:0] cfg_word;
  logic [4:0] vec_base;
  logic [7:0] irq_lines, irq_mask, in_service;
  logic       ack;
  logic [2:0] cas_in;
  logic       int_req;
  logic [2:0] cas_out;
  logic [7:0] data_out;
  logic       data_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  casc_ack_unit u_casc_ack_unit (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .cfg_word(cfg_word),
    .vec_base(vec_base), .irq_lines(irq_lines), .irq_mask(irq_mask),
    .in_service(in_service), .ack(ack), .cas_in(cas_in), .int_req(int_req),
    .cas_out(cas_out), .data_out(data_out), .data_oe(data_oe)
  );

  typedef struct packed {
    logic       m;
    logic [7:0] cfg, req, msk, srv;
    logic [2:0] cin;
    logic [4:0] base;
    logic       e_int;
    logic [2:0] e_cas;
    logic       e_oe;
    logic [7:0] e_dat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b1, 8'h10, 8'h10, 8'h00, 8'h00, 3'd0, 5'h08, 1'b1, 3'd4, 1'b0, 8'h00},
    '{1'b1, 8'h10, 8'h14, 8'h00, 8'h00, 3'd0, 5'h08, 1'b1, 3'd0, 1'b1, 8'h42},
    '{1'b1, 8'h00, 8'h14, 8'h04, 8'h00, 3'd0, 5'h08, 1'b1, 3'd0, 1'b1, 8'h44},
    '{1'b1, 8'hFF, 8'h80, 8'h00, 8'h08, 3'd0, 5'h08, 1'b0, 3'd0, 1'b0, 8'h00},
    '{1'b1, 8'h80, 8'h81, 8'h01, 8'h00, 3'd0, 5'h08, 1'b1, 3'd7, 1'b0, 8'h00},
    '{1'b0, 8'h04, 8'h02, 8'h00, 8'h00, 3'd4, 5'h18, 1'b1, 3'd0, 1'b1, 8'hC1},
    '{1'b0, 8'h04, 8'h02, 8'h00, 8'h00, 3'd3, 5'h18, 1'b1, 3'd0, 1'b0, 8'h00},
    '{1'b0, 8'h05, 8'h21, 8'h00, 8'h01, 3'd5, 5'h18, 1'b0, 3'd0, 1'b0, 8'h00},
    '{1'b0, 8'hFD, 8'h08, 8'h00, 8'h10, 3'd5, 5'h02, 1'b1, 3'd0, 1'b1, 8'h13},
    '{1'b1, 8'h01, 8'h01, 8'h00, 8'h00, 3'd0, 5'h08, 1'b1, 3'd0, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic apply(input vec_t v);
    is_master = v.m; cfg_word = v.cfg; irq_lines = v.req; irq_mask = v.msk;
    in_service = v.srv; cas_in = v.cin; vec_base = v.base;
  endtask

  // full two-pulse acknowledge, checked after each phase step
  task automatic ack_cycle(input int row, input logic [2:0] e_cas,
                           input logic e_oe, input logic [7:0] e_dat);
    ack = 1'b1;
    @(negedge clk);
    chk($sformatf("R4/R6 row%0d first-pulse cas", row), cas_out, e_cas);
    chk($sformatf("R7 row%0d first-pulse oe", row), data_oe, 0);
    chk($sformatf("R8 row%0d first-pulse data", row), data_out, 0);
    ack = 1'b0;
    @(negedge clk);
    chk($sformatf("R4 row%0d gap cas", row), cas_out, e_cas);
    chk($sformatf("R7 row%0d gap oe", row), data_oe, 0);
    ack = 1'b1;
    @(negedge clk);
    chk($sformatf("R4 row%0d second cas", row), cas_out, e_cas);
    chk($sformatf("R5/R7/R9/R10 row%0d second oe", row), data_oe, e_oe);
    chk($sformatf("R5/R8 row%0d second data", row), data_out, e_dat);
    ack = 1'b0;
    @(negedge clk);
    chk($sformatf("R6 row%0d idle cas", row), cas_out, 0);
    chk($sformatf("R8 row%0d idle oe", row), data_oe, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ack = 1'b0;
    apply('{1'b1, 8'h10, 8'h10, 8'h00, 8'h00, 3'd0, 5'h08, 1'b0, 3'd0, 1'b0, 8'h00});
    repeat (3) @(negedge clk);
    // R1: reset state, even with a live request and ack high
    ack = 1'b1;
    @(negedge clk);
    chk("R1 reset int_req", int_req, 0);
    chk("R1 reset cas_out", cas_out, 0);
    chk("R1 reset data_oe", data_oe, 0);
    chk("R1 reset data_out", data_out, 0);
    ack = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset cas_out", cas_out, 0);
    chk("R1 after reset data_oe", data_oe, 0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      chk($sformatf("R2 row%0d int_req", i), int_req, TBL[i].e_int);
      ack_cycle(i, TBL[i].e_cas, TBL[i].e_oe, TBL[i].e_dat);
    end

    // R3: inputs change after the first pulse; the captured cascaded winner stays
    apply('{1'b1, 8'h10, 8'h10, 8'h00, 8'h00, 3'd0, 5'h08, 1'b0, 3'd0, 1'b0, 8'h00});
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    irq_lines = 8'h01; cfg_word = 8'h00; is_master = 1'b0; cas_in = 3'd0;
    ack = 1'b0;
    @(negedge clk);
    chk("R3 gap cas after input change", cas_out, 4);
    ack = 1'b1;
    @(negedge clk);
    chk("R3 second cas after input change", cas_out, 4);
    chk("R3 second oe after input change", data_oe, 0);
    ack = 1'b0;
    @(negedge clk);
    chk("R3 idle cas", cas_out, 0);

    // R9: no winner at first pulse, winner appears before second pulse
    apply('{1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 5'h08, 1'b0, 3'd0, 1'b0, 8'h00});
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    irq_lines = 8'h02;
    ack = 1'b0;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    chk("R9 late winner oe", data_oe, 0);
    chk("R9 late winner data", data_out, 0);
    ack = 1'b0;
    @(negedge clk);

    // R6: slave mode with upper cfg bits set never drives cascade
    apply('{1'b0, 8'hF8, 8'h80, 8'h00, 8'h00, 3'd0, 5'h08, 1'b0, 3'd0, 1'b0, 8'h00});
    @(negedge clk);
    chk("R2 slave int_req input7", int_req, 1);
    ack_cycle(99, 3'd0, 1'b1, 8'h47);

    done = 1;
    finish_run();
  end
endmodule